// File: doc/BRIEF.md
# Peripheral DMA Channel Pair Controller

This block moves data between one peripheral and memory without processor involvement. A receive channel takes words that the peripheral offers and writes them into memory. A transmit channel reads words from memory and hands them to the peripheral. Each channel keeps an active address and a remaining-transfer count. A second, queued address/count pair lets software prepare the next buffer while the current one drains, so the stream continues without a gap.

Software programs the block through a small word-addressed register port. Reads return one cycle after the address is presented. The block owns a single request/acknowledge memory port that is shared by both channels, with one access in flight at a time. Four level flags report when the active buffer of each channel has drained and when both of its buffers are used up. A global size input selects byte, half-word or word steps for the address.

Top module: `pdc_pair`

## Requirements
- R1: Register offsets (reg_addr): 0 rx address, 1 rx count, 2 rx queued address, 3 rx queued count, 4 tx address, 5 tx count, 6 tx queued address, 7 tx queued count, 8 control (write), 9 status. A write takes effect at the clock edge. reg_rdata shows the register at the address of the previous cycle. Counts are 16 bits, written from reg_wdata[15:0] and read back zero-extended.
- R2: After each acknowledged transfer, the channel's address advances by 1, 2 or 4 when cfg_size is 0, 1 or 2 (3 counts as 4).
- R3: Each acknowledged transfer lowers the channel's count by one. A channel whose count is zero issues no memory request.
- R4: Whenever a channel's count becomes zero while its queued count is nonzero, the queued address and count move into the active registers in that same cycle, and the queued count clears. This holds both when a transfer finishes and when software writes the queued count while the active count is zero.
- R5: rx_end is high exactly when the rx count is zero. rx_full is high when both rx counts are zero. tx_end and tx_empty follow the same rule for the tx counts. After reset all counts are zero, so all four flags are high.
- R6: Control bits: bit0 enables rx, bit1 disables rx, bit2 enables tx, bit3 disables tx. A disable bit wins over the enable bit written with it. Status bit0 reads 1 when rx is enabled, and bit1 reads 1 when tx is enabled. Reset leaves both channels disabled.
- R7: Disabling a channel while its request is outstanding lets that request finish and update the count and address. No further request follows.
- R8: Writing an address or count while a channel is enabled applies to the following transfers. A software write to a register overrides the hardware update of that same register in the same cycle.
- R9: mem_req keeps mem_addr, mem_we and mem_wdata stable until mem_ack. Only one access is outstanding on the port. When both channels wait, the rx channel is served first.
- R10: An enabled rx channel with a nonzero count, rx_ready high and no request in flight captures rx_data, pulses rx_pop for one cycle and writes the data (mem_we=1) at its address.
- R11: An enabled tx channel with a nonzero count and tx_ready high reads (mem_we=0) at its address. On mem_ack it presents mem_rdata on tx_data with a one-cycle tx_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size | input | 2 | Transfer size: 0 byte, 1 half-word, 2 word |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| rx_ready | input | 1 | Peripheral has receive data |
| rx_data | input | 32 | Receive data from peripheral |
| rx_pop | output | 1 | Receive data taken |
| tx_ready | input | 1 | Peripheral can accept data |
| tx_data | output | 32 | Transmit data to peripheral |
| tx_valid | output | 1 | tx_data valid for one cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| rx_end | output | 1 | Rx active count is zero |
| rx_full | output | 1 | Both rx counts are zero |
| tx_end | output | 1 | Tx active count is zero |
| tx_empty | output | 1 | Both tx counts are zero |

## Verification
Two events can land on the same edge. The first is the final decrement of an active count and the reload from the queued pair. The bench provokes this by draining two-buffer chains of several sizes, and it judges the result by the final address, the total number of memory writes, and the fact that rx_end never rises between the two buffers. The second is that both channels can raise a request in the same cycle. This happens when both are enabled by a single control write, and the bench checks that the first port access is the receive write and that both accesses finish.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [3:0] {
    RG_RX_PTR  = 4'd0,
    RG_RX_CNT  = 4'd1,
    RG_RX_NPTR = 4'd2,
    RG_RX_NCNT = 4'd3,
    RG_TX_PTR  = 4'd4,
    RG_TX_CNT  = 4'd5,
    RG_TX_NPTR = 4'd6,
    RG_TX_NCNT = 4'd7,
    RG_CTRL    = 4'd8,
    RG_STAT    = 4'd9
  } reg_ofs_e;

  localparam int CTL_RX_EN  = 0;
  localparam int CTL_RX_DIS = 1;
  localparam int CTL_TX_EN  = 2;
  localparam int CTL_TX_DIS = 3;

  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      2'd0:    size_step = 3'd1;
      2'd1:    size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pdc_chan.sv
module pdc_chan #(
  parameter int  AW    = 32,
  parameter int  DW    = 32,
  parameter int  CW    = 16,
  parameter bit  IS_RX = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] step,
  input  logic          trig,
  input  logic [DW-1:0] din,
  input  logic          wr_ptr,
  input  logic          wr_cnt,
  input  logic          wr_nptr,
  input  logic          wr_ncnt,
  input  logic [31:0]   wdata,
  input  logic          ack,
  output logic [AW-1:0] ptr,
  output logic [CW-1:0] cnt,
  output logic [AW-1:0] nptr,
  output logic [CW-1:0] ncnt,
  output logic          req,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dout,
  output logic          strobe
);
  logic          issue;
  logic          done;
  logic [AW-1:0] ptr_a, nptr_a;
  logic [CW-1:0] cnt_a, ncnt_a;
  logic          reload;

  assign issue = en && (cnt != '0) && !req && trig;
  assign done  = ack && req;

  always_comb begin
    ptr_a  = wr_ptr  ? AW'(wdata) : (done ? ptr + step : ptr);
    cnt_a  = wr_cnt  ? CW'(wdata) : ((done && cnt != '0) ? cnt - CW'(1) : cnt);
    nptr_a = wr_nptr ? AW'(wdata) : nptr;
    ncnt_a = wr_ncnt ? CW'(wdata) : ncnt;
    reload = (cnt_a == '0) && (ncnt_a != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      cnt  <= '0;
      nptr <= '0;
      ncnt <= '0;
      req  <= 1'b0;
      addr <= '0;
    end else begin
      nptr <= nptr_a;
      if (reload) begin
        ptr  <= nptr_a;
        cnt  <= ncnt_a;
        ncnt <= '0;
      end else begin
        ptr  <= ptr_a;
        cnt  <= cnt_a;
        ncnt <= ncnt_a;
      end
      if (done)       req <= 1'b0;
      else if (issue) req <= 1'b1;
      if (issue) addr <= ptr;
    end
  end

  generate
    if (IS_RX) begin : g_rx
      always_ff @(posedge clk) begin
        if (rst) begin
          dout   <= '0;
          strobe <= 1'b0;
        end else begin
          strobe <= issue;
          if (issue) dout <= din;
        end
      end
    end else begin : g_tx
      always_ff @(posedge clk) begin
        if (rst) begin
          dout   <= '0;
          strobe <= 1'b0;
        end else begin
          strobe <= done;
          if (done) dout <= din;
        end
      end
    end
  endgenerate

  // R9: an outstanding request keeps its address and data
  p_hold_req_r9: assert property (@(posedge clk) disable iff (rst)
    req && !ack |=> req && $stable(addr) && $stable(dout));
  // R3: count drops by one per completed transfer
  p_dec_r3: assert property (@(posedge clk) disable iff (rst)
    done && !wr_cnt && cnt > CW'(1) |=> cnt == $past(cnt) - CW'(1));
  // R3: no request starts while disabled or drained
  p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !req && (cnt == '0 || !en) |=> !req);
  // R2: address steps by the transfer size
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    done && !wr_ptr && !wr_cnt && cnt > CW'(1) |=> ptr == $past(ptr) + $past(step));
  // R4: queued buffer takes over on the final transfer
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    done && cnt == CW'(1) && ncnt != '0 && !wr_ptr && !wr_cnt && !wr_nptr && !wr_ncnt
    |=> cnt == $past(ncnt) && ncnt == '0 && ptr == $past(nptr));
endmodule

// File: rtl/pdc_arb.sv
module pdc_arb #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_req,
  input  logic [AW-1:0] rx_addr,
  input  logic [DW-1:0] rx_data,
  input  logic          tx_req,
  input  logic [AW-1:0] tx_addr,
  input  logic [DW-1:0] tx_data,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rx_ack,
  output logic          tx_ack
);
  logic [1:0] owner;  // bit0 rx, bit1 tx

  always_ff @(posedge clk) begin
    if (rst) begin
      owner <= 2'b00;
    end else if (owner == 2'b00) begin
      if (rx_req)      owner <= 2'b01;
      else if (tx_req) owner <= 2'b10;
    end else if (mem_ack) begin
      owner <= 2'b00;
    end
  end

  assign mem_req   = |owner;
  assign mem_we    = owner[0];
  assign mem_addr  = owner[1] ? tx_addr : rx_addr;
  assign mem_wdata = owner[1] ? tx_data : rx_data;
  assign rx_ack    = mem_ack && owner[0];
  assign tx_ack    = mem_ack && owner[1];

  p_one_owner_r9: assert property (@(posedge clk) disable iff (rst) $onehot0(owner));
  p_port_hold_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  p_rx_first_r9: assert property (@(posedge clk) disable iff (rst)
    !mem_req && rx_req && tx_req |=> mem_req && mem_we);
endmodule

// File: rtl/pdc_pair.sv
module pdc_pair #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_size,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  output logic          rx_pop,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          rx_end,
  output logic          rx_full,
  output logic          tx_end,
  output logic          tx_empty
);
  import pdc_pkg::*;

  logic [AW-1:0] step;
  logic          rx_en, tx_en, ctl_wr;
  logic [AW-1:0] rx_ptr, rx_nptr, tx_ptr, tx_nptr, rx_addr, tx_addr;
  logic [CW-1:0] rx_cnt, rx_ncnt, tx_cnt, tx_ncnt;
  logic          rx_req, tx_req, rx_ack, tx_ack;
  logic [DW-1:0] rx_dout;

  assign step   = AW'(size_step(cfg_size));
  assign ctl_wr = reg_we && (reg_addr == RG_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
    end else if (ctl_wr) begin
      if (reg_wdata[CTL_RX_DIS])     rx_en <= 1'b0;
      else if (reg_wdata[CTL_RX_EN]) rx_en <= 1'b1;
      if (reg_wdata[CTL_TX_DIS])     tx_en <= 1'b0;
      else if (reg_wdata[CTL_TX_EN]) tx_en <= 1'b1;
    end
  end

  pdc_chan #(.AW(AW), .DW(DW), .CW(CW), .IS_RX(1'b1)) u_rx (
    .clk(clk), .rst(rst), .en(rx_en), .step(step), .trig(rx_ready), .din(rx_data),
    .wr_ptr (reg_we && reg_addr == RG_RX_PTR),
    .wr_cnt (reg_we && reg_addr == RG_RX_CNT),
    .wr_nptr(reg_we && reg_addr == RG_RX_NPTR),
    .wr_ncnt(reg_we && reg_addr == RG_RX_NCNT),
    .wdata(reg_wdata), .ack(rx_ack),
    .ptr(rx_ptr), .cnt(rx_cnt), .nptr(rx_nptr), .ncnt(rx_ncnt),
    .req(rx_req), .addr(rx_addr), .dout(rx_dout), .strobe(rx_pop));

  pdc_chan #(.AW(AW), .DW(DW), .CW(CW), .IS_RX(1'b0)) u_tx (
    .clk(clk), .rst(rst), .en(tx_en), .step(step), .trig(tx_ready), .din(mem_rdata),
    .wr_ptr (reg_we && reg_addr == RG_TX_PTR),
    .wr_cnt (reg_we && reg_addr == RG_TX_CNT),
    .wr_nptr(reg_we && reg_addr == RG_TX_NPTR),
    .wr_ncnt(reg_we && reg_addr == RG_TX_NCNT),
    .wdata(reg_wdata), .ack(tx_ack),
    .ptr(tx_ptr), .cnt(tx_cnt), .nptr(tx_nptr), .ncnt(tx_ncnt),
    .req(tx_req), .addr(tx_addr), .dout(tx_data), .strobe(tx_valid));

  pdc_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst(rst),
    .rx_req(rx_req), .rx_addr(rx_addr), .rx_data(rx_dout),
    .tx_req(tx_req), .tx_addr(tx_addr), .tx_data(tx_data),
    .mem_ack(mem_ack), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rx_ack(rx_ack), .tx_ack(tx_ack));

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RG_RX_PTR:  reg_rdata <= 32'(rx_ptr);
        RG_RX_CNT:  reg_rdata <= 32'(rx_cnt);
        RG_RX_NPTR: reg_rdata <= 32'(rx_nptr);
        RG_RX_NCNT: reg_rdata <= 32'(rx_ncnt);
        RG_TX_PTR:  reg_rdata <= 32'(tx_ptr);
        RG_TX_CNT:  reg_rdata <= 32'(tx_cnt);
        RG_TX_NPTR: reg_rdata <= 32'(tx_nptr);
        RG_TX_NCNT: reg_rdata <= 32'(tx_ncnt);
        RG_STAT:    reg_rdata <= {30'd0, tx_en, rx_en};
        default:    reg_rdata <= '0;
      endcase
    end
  end

  assign rx_end   = (rx_cnt == '0);
  assign rx_full  = (rx_cnt == '0) && (rx_ncnt == '0);
  assign tx_end   = (tx_cnt == '0);
  assign tx_empty = (tx_cnt == '0) && (tx_ncnt == '0);

  // R6: disable bit dominates
  p_dis_wins_r6: assert property (@(posedge clk) disable iff (rst)
    ctl_wr && reg_wdata[CTL_RX_DIS] |=> !rx_en);
  // R7: an in-flight request survives a disable
  p_flight_r7: assert property (@(posedge clk) disable iff (rst)
    rx_req && !rx_ack && ctl_wr && reg_wdata[CTL_RX_DIS] |=> rx_req);
endmodule

// File: tb/pdc_pair_tb.sv
`timescale 1ns/1ps
module pdc_pair_tb_top;
  localparam logic [31:0] KEY = 32'hA5A5_0000;

  typedef struct packed {
    logic [1:0]  sz;
    logic [31:0] p;
    logic [15:0] c;
    logic [31:0] np;
    logic [15:0] nc;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{2'd0, 32'h0000_0100, 16'd3, 32'h0000_0180, 16'd2},
    '{2'd1, 32'h0000_0200, 16'd4, 32'h0000_0000, 16'd0},
    '{2'd2, 32'h0000_0300, 16'd2, 32'h0000_0400, 16'd3},
    '{2'd2, 32'h0000_0010, 16'd1, 32'h0000_0020, 16'd1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0]  cfg_size = 2'd2;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        rx_ready = 1'b0, rx_pop, tx_ready = 1'b0, tx_valid;
  logic [31:0] rx_data = 32'h1234_5678, tx_data;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        rx_end, rx_full, tx_end, tx_empty;

  int total = 0, bad = 0;
  int n_acc = 0, n_wr = 0, n_tx = 0, n_pop = 0;
  logic stall = 1'b0, mon_en = 1'b0, saw_end = 1'b0;
  logic [31:0] mem [0:1023];
  logic [31:0] tx_got [0:3];
  logic [31:0] v;

  always #2.5 clk = ~clk;

  pdc_pair dut_i (
    .clk(clk), .rst(rst), .cfg_size(cfg_size), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_pop(rx_pop), .tx_ready(tx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rx_end(rx_end), .rx_full(rx_full),
    .tx_end(tx_end), .tx_empty(tx_empty));

  // memory and peripheral model, acting on the falling edge
  always @(negedge clk) begin
    if (tx_valid) begin
      if (n_tx < 4) tx_got[n_tx] = tx_data;
      n_tx++;
    end
    if (rx_pop) n_pop++;
    if (mon_en && rx_end && !rx_full) saw_end = 1'b1;
    if (rst) mem_ack = 1'b0;
    else if (mem_req && !mem_ack && !stall) begin
      mem_ack = 1'b1;
      n_acc++;
      if (mem_we) begin
        mem[mem_addr[9:0]] = mem_wdata;
        n_wr++;
      end
      mem_rdata = mem_addr ^ KEY;
    end else mem_ack = 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_for(input int which);
    for (int i = 0; i < 400; i++) begin
      if (which == 0 && mem_req) break;
      if (which == 1 && rx_full) break;
      if (which == 2 && tx_empty && n_tx >= 2) break;
      if (which == 3 && rx_full && tx_empty) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    rd(4'd9, v); chk("R6 reset status", v, 32'd0);
    rd(4'd1, v); chk("R1 reset rx count", v, 32'd0);
    chk("R5 reset flags", {28'd0, rx_end, rx_full, tx_end, tx_empty}, 32'hF);
    chk("R9 reset no request", {31'd0, mem_req}, 32'd0);

    // vector table: two-buffer receive chains
    for (int k = 0; k < 4; k++) begin
      logic [31:0] stp, exp_ptr;
      cfg_size = VECS[k].sz;
      stp = (VECS[k].sz == 2'd0) ? 32'd1 : (VECS[k].sz == 2'd1) ? 32'd2 : 32'd4;
      wr(4'd0, VECS[k].p);
      wr(4'd1, {16'd0, VECS[k].c});
      wr(4'd2, VECS[k].np);
      wr(4'd3, {16'd0, VECS[k].nc});
      n_wr = 0; saw_end = 1'b0; mon_en = 1'b1; rx_ready = 1'b1;
      wr(4'd8, 32'h1);
      wait_for(1);
      rx_ready = 1'b0; mon_en = 1'b0;
      wr(4'd8, 32'h2);
      exp_ptr = (VECS[k].nc != 0) ? VECS[k].np + VECS[k].nc * stp : VECS[k].p + VECS[k].c * stp;
      chk("R3 write count", n_wr, 32'(VECS[k].c) + 32'(VECS[k].nc));
      rd(4'd0, v); chk("R2 final address", v, exp_ptr);
      rd(4'd3, v); chk("R4 queued count cleared", v, 32'd0);
      chk("R5 rx flags drained", {30'd0, rx_end, rx_full}, 32'h3);
      if (VECS[k].nc != 0) chk("R4 no end gap", {31'd0, saw_end}, 32'd0);
    end

    // R11 transmit reads
    cfg_size = 2'd2; n_tx = 0;
    wr(4'd4, 32'h40); wr(4'd5, 32'd2);
    tx_ready = 1'b1;
    wr(4'd8, 32'h4);
    wait_for(2);
    tx_ready = 1'b0;
    wr(4'd8, 32'h8);
    chk("R11 tx count", n_tx, 32'd2);
    chk("R11 tx word0", tx_got[0], 32'h40 ^ KEY);
    chk("R11 tx word1", tx_got[1], 32'h44 ^ KEY);
    chk("R5 tx flags", {30'd0, tx_end, tx_empty}, 32'h3);

    // R9 both channels requesting in the same cycle
    wr(4'd0, 32'h80); wr(4'd1, 32'd1); wr(4'd4, 32'h90); wr(4'd5, 32'd1);
    rx_data = 32'hCAFE_0001; n_acc = 0; n_pop = 0;
    rx_ready = 1'b1; tx_ready = 1'b1;
    wr(4'd8, 32'h5);
    wait_for(0);
    chk("R9 rx served first we", {31'd0, mem_we}, 32'd1);
    chk("R9 rx served first addr", mem_addr, 32'h80);
    wait_for(3);
    rx_ready = 1'b0; tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 both served", n_acc, 32'd2);
    chk("R10 rx data written", mem[10'h80], 32'hCAFE_0001);
    chk("R10 one pop", n_pop, 32'd1);
    wr(4'd8, 32'hA);

    // R7 disable with a request in flight
    stall = 1'b1; n_acc = 0;
    wr(4'd0, 32'h500); wr(4'd1, 32'd5);
    rx_ready = 1'b1;
    wr(4'd8, 32'h1);
    wait_for(0);
    wr(4'd8, 32'h2);
    rd(4'd9, v); chk("R7 disabled", v, 32'd0);
    chk("R7 request kept", {31'd0, mem_req}, 32'd1);
    stall = 1'b0;
    repeat (12) @(negedge clk);
    chk("R7 single access", n_acc, 32'd1);
    chk("R7 port idle", {31'd0, mem_req}, 32'd0);
    rd(4'd1, v); chk("R7 count updated", v, 32'd4);
    rd(4'd0, v); chk("R7 address updated", v, 32'h504);
    rx_ready = 1'b0;

    // R8 rewrite while enabled
    wr(4'd0, 32'h600); wr(4'd1, 32'd2);
    wr(4'd8, 32'h1);
    wr(4'd0, 32'h700); wr(4'd1, 32'd3);
    n_wr = 0; rx_ready = 1'b1;
    wait_for(0);
    chk("R8 new address used", mem_addr, 32'h700);
    wait_for(1);
    rx_ready = 1'b0;
    wr(4'd8, 32'h2);
    chk("R8 new count used", n_wr, 32'd3);
    rd(4'd0, v); chk("R8 final address", v, 32'h70C);

    // R6 control bit priority
    wr(4'd8, 32'h3); rd(4'd9, v); chk("R6 disable wins", v, 32'd0);
    wr(4'd8, 32'h5); rd(4'd9, v); chk("R6 both enabled", v, 32'd3);
    wr(4'd8, 32'h8); rd(4'd9, v); chk("R6 tx disabled", v, 32'd1);
    wr(4'd8, 32'h2);

    // R1 readback and R4 load through queued write
    wr(4'd6, 32'hABCD_0000); rd(4'd6, v); chk("R1 queued address", v, 32'hABCD_0000);
    wr(4'd5, 32'hFFFF_1234); rd(4'd5, v); chk("R1 count zero-extended", v, 32'h1234);
    chk("R5 tx flags busy", {30'd0, tx_end, tx_empty}, 32'd0);
    wr(4'd2, 32'h900); wr(4'd3, 32'd5);
    rd(4'd0, v); chk("R4 queued address loaded", v, 32'h900);
    rd(4'd1, v); chk("R4 queued count loaded", v, 32'd5);
    rd(4'd3, v); chk("R4 queued count zero", v, 32'd0);

    finish_up();
  end
endmodule